// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Output Writes

This block is a memory-mapped general-purpose I/O controller for 128 pins, organised as four banks of 32. Software reaches it over a plain 32-bit register bus: a request strobe, a write flag, a byte address and write data. Read data returns one cycle later together with a valid pulse. Every pin has a direction bit, an output-enable bit and an output latch bit. Its pad level is brought through a two-flop synchronizer and can be read back per bank.

The central feature is the masked output write. Each 16-pin group has its own write register, so one store can change any subset of that group's outputs without a read-modify-write sequence. In that store the upper halfword is a keep-mask and the lower halfword carries the new values. Each pin drives its pad through a value line and an enable line. The enable is raised only when the pin is both set as an output and enabled.

The bus has no back-pressure. Every request is accepted in the cycle it is presented, and a read answers on the following cycle without fail. A master must therefore be ready to take read data one cycle after it issues a read.

Top module: `gpio_banked`

## Requirements
- R1: After reset every output latch, direction bit and output-enable bit is 0, so `pad_out` and `pad_oe` are all zero and every pin is an undriven input.
- R2: A write to byte address 4×k (k = 0..7) updates pins 16k..16k+15. For each bit i in 0..15, a wdata bit 16+i of 0 loads latch bit i from wdata bit i, and a wdata bit 16+i of 1 leaves that latch bit unchanged.
- R3: A read of byte address 4×k returns the output latches of group k in bits 15:0, with bits 31:16 zero.
- R4: The direction register of bank b sits at byte address 0x204 + 0x40×b. Its bit i belongs to pin 32b+i, where 1 means output and 0 means input. It reads back as written.
- R5: The output-enable register of bank b sits at byte address 0x208 + 0x40×b, with the same bit-to-pin mapping. It reads back as written.
- R6: `pad_oe` bit n is 1 exactly when pin n has both its direction bit and its output-enable bit set. `pad_out` always shows the output latch, whatever the direction.
- R7: A read of byte address 0x060 + 4×b returns the synchronized level of pins 32b..32b+31. A change on `pad_in` driven before clock edge 1 is not visible to a read sampled at edge 1. It is visible to a read sampled at edge 3.
- R8: Writes to the input registers, to unmapped addresses and to addresses that are not word-aligned change no state. Reads of such unmapped or misaligned addresses return zero.
- R9: `bus_rvalid` is 1 in the cycle after a read request, with `bus_rdata` valid. It is 0 after a write or an idle cycle.
- R10: A write takes effect on the pins in the cycle after it is accepted. Without a write, `pad_out` and `pad_oe` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | 128 | Pad input levels |
| pad_out | output | 128 | Output latch value per pin |
| pad_oe | output | 128 | Drive enable per pin |

## Verification
On every cycle the assertions check four things: the zero state after reset, the masked-write rule on group 0 at the port level, that the pins hold when there is no write, and the read-valid timing. They also check that clearing bank 0's direction register releases all of its pads, and that an unmapped read returns zero. Only the bench scenarios can show the other properties. These are the masked-write rule for every group, the direction and enable combinations for each bank, the exact synchronizer latency, the readback of every register, and the fact that writes to read-only or unmapped addresses leave no trace.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    RK_NONE  = 3'd0,
    RK_MASK  = 3'd1,
    RK_INPUT = 3'd2,
    RK_DIR   = 3'd3,
    RK_OE    = 3'd4
  } reg_kind_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int AW        = 12,
  parameter int IN_BASE   = 'h060,
  parameter int DIR_BASE  = 'h204,
  parameter int OE_BASE   = 'h208,
  parameter int STRIDE    = 'h40,
  localparam int BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [AW-1:0] addr_i,
  output reg_kind_e     kind_o,
  output logic [BW-1:0] bank_o,
  output logic          half_o
);
  localparam logic [AW-1:0] IN_B   = AW'(IN_BASE);
  localparam logic [AW-1:0] DIR_B  = AW'(DIR_BASE);
  localparam logic [AW-1:0] OE_B   = AW'(OE_BASE);
  localparam logic [AW-1:0] STR    = AW'(STRIDE);
  localparam logic [AW-1:0] NB     = AW'(NUM_BANKS);
  localparam logic [AW-1:0] NGROUP = AW'(2 * NUM_BANKS);

  logic [AW-1:0] in_off, dir_off, oe_off;
  logic [AW-1:0] dir_idx, oe_idx;

  assign in_off  = addr_i - IN_B;
  assign dir_off = addr_i - DIR_B;
  assign oe_off  = addr_i - OE_B;
  assign dir_idx = dir_off / STR;
  assign oe_idx  = oe_off / STR;

  always_comb begin
    kind_o = RK_NONE;
    bank_o = '0;
    half_o = 1'b0;
    if (addr_i[1:0] == 2'b00) begin
      if ((addr_i >> 2) < NGROUP) begin
        kind_o = RK_MASK;
        bank_o = BW'(addr_i >> 3);
        half_o = addr_i[2];
      end else if (addr_i >= IN_B && (in_off >> 2) < NB) begin
        kind_o = RK_INPUT;
        bank_o = BW'(in_off >> 2);
      end else if (addr_i >= DIR_B && (dir_off % STR) == '0 && dir_idx < NB) begin
        kind_o = RK_DIR;
        bank_o = BW'(dir_idx);
      end else if (addr_i >= OE_B && (oe_off % STR) == '0 && oe_idx < NB) begin
        kind_o = RK_OE;
        bank_o = BW'(oe_idx);
      end
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int DW = 32,
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mask_we_i,
  input  logic          dir_we_i,
  input  logic          oe_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] pad_in_i,
  output logic [DW-1:0] dout_o,
  output logic [DW-1:0] dir_o,
  output logic [DW-1:0] oe_o,
  output logic [DW-1:0] din_o
);
  logic [DW-1:0] dir_q, oe_q, dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      oe_q  <= '0;
    end else begin
      if (dir_we_i) dir_q <= wdata_i;
      if (oe_we_i)  oe_q  <= wdata_i;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HW-1:0] keep;
    logic [HW-1:0] newv;
    assign keep = wdata_i[DW-1:HW];
    assign newv = wdata_i[HW-1:0];
    always_ff @(posedge clk) begin
      if (rst) begin
        dout_q[h*HW +: HW] <= '0;
      end else if (mask_we_i[h]) begin
        dout_q[h*HW +: HW] <= (newv & ~keep) | (dout_q[h*HW +: HW] & keep);
      end
    end
  end

  gpio_sync2 #(.W(DW)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (pad_in_i),
    .q_o (din_o)
  );

  assign dout_o = dout_q;
  assign dir_o  = dir_q;
  assign oe_o   = oe_q;
endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DW        = 32,
  parameter int AW        = 12,
  localparam int PINS     = NUM_BANKS * DW,
  localparam int HW       = DW / 2,
  localparam int BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_req,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_rvalid,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe
);
  reg_kind_e     kind;
  logic [BW-1:0] bank_sel;
  logic          half_sel;
  logic          wr_go, rd_go;

  logic [DW-1:0] dout_w [NUM_BANKS];
  logic [DW-1:0] dir_w  [NUM_BANKS];
  logic [DW-1:0] oe_w   [NUM_BANKS];
  logic [DW-1:0] din_w  [NUM_BANKS];

  assign wr_go = bus_req & bus_we;
  assign rd_go = bus_req & ~bus_we;

  gpio_addr_dec #(.NUM_BANKS(NUM_BANKS), .AW(AW)) dec_i (
    .addr_i (bus_addr),
    .kind_o (kind),
    .bank_o (bank_sel),
    .half_o (half_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic       hit;
    logic [1:0] mwe;
    assign hit    = wr_go && (bank_sel == BW'(b));
    assign mwe[0] = hit && (kind == RK_MASK) && !half_sel;
    assign mwe[1] = hit && (kind == RK_MASK) && half_sel;

    gpio_bank #(.DW(DW)) bank_i (
      .clk       (clk),
      .rst       (rst),
      .mask_we_i (mwe),
      .dir_we_i  (hit && (kind == RK_DIR)),
      .oe_we_i   (hit && (kind == RK_OE)),
      .wdata_i   (bus_wdata),
      .pad_in_i  (pad_in[b*DW +: DW]),
      .dout_o    (dout_w[b]),
      .dir_o     (dir_w[b]),
      .oe_o      (oe_w[b]),
      .din_o     (din_w[b])
    );

    assign pad_out[b*DW +: DW] = dout_w[b];
    assign pad_oe[b*DW +: DW]  = dir_w[b] & oe_w[b];
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (kind)
      RK_MASK:  rd_mux = {{HW{1'b0}}, (half_sel ? dout_w[bank_sel][DW-1:HW]
                                                : dout_w[bank_sel][HW-1:0])};
      RK_INPUT: rd_mux = din_w[bank_sel];
      RK_DIR:   rd_mux = dir_w[bank_sel];
      RK_OE:    rd_mux = oe_w[bank_sel];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_go;
      if (rd_go) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_banked_chk.sv
module gpio_banked_chk #(
  parameter int PINS = 128,
  parameter int DW   = 32,
  parameter int AW   = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_req,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic            bus_rvalid,
  input logic [PINS-1:0] pad_out,
  input logic [PINS-1:0] pad_oe
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (pad_out == '0 && pad_oe == '0 && !bus_rvalid));

  // R2
  masked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_addr == '0) |=>
      pad_out[15:0] == (($past(bus_wdata[15:0]) & ~$past(bus_wdata[31:16]))
                      | ($past(pad_out[15:0]) & $past(bus_wdata[31:16]))));

  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_we) |=> $stable(pad_out));

  // R10
  hold_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_we) |=> $stable(pad_oe));

  // R9
  rvalid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> bus_rvalid);

  // R9
  rvalid_low_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && !bus_we) |=> !bus_rvalid);

  // R6
  release_bank0_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_addr == AW'('h204) && bus_wdata == '0) |=>
      pad_oe[31:0] == '0);

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && bus_addr == AW'('h100)) |=> bus_rdata == '0);
endmodule

bind gpio_banked gpio_banked_chk #(.PINS(PINS), .DW(DW), .AW(AW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe)
);

// File: tb/gpio_banked_tb.sv
module gpio_banked_tb_top;
  localparam int NB = 4;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int PINS = NB * DW;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_req = 1'b0;
  logic            bus_we = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [DW-1:0]   bus_rdata;
  logic            bus_rvalid;
  logic [PINS-1:0] pad_in = '0;
  logic [PINS-1:0] pad_out;
  logic [PINS-1:0] pad_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [PINS-1:0] m_out = '0;
  logic [PINS-1:0] m_dir = '0;
  logic [PINS-1:0] m_oe  = '0;

  always #10 clk = ~clk;

  gpio_banked #(.NUM_BANKS(NB), .DW(DW), .AW(AW)) dut_i (
    .clk (clk), .rst (rst), .bus_req (bus_req), .bus_we (bus_we),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .bus_rvalid (bus_rvalid), .pad_in (pad_in), .pad_out (pad_out),
    .pad_oe (pad_oe)
  );

  task automatic chk(input string req, input logic [PINS-1:0] act,
                     input logic [PINS-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
    chk("R9 rvalid after read", PINS'(bus_rvalid), PINS'(1));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 pad_out", pad_out, '0);
    chk("R1 pad_oe", pad_oe, '0);
    for (int b = 0; b < NB; b++) begin
      rd(AW'('h204 + 'h40 * b), r);
      chk("R1 dir reset", PINS'(r), '0);
    end

    // R2/R3 masked write sweep over every group
    for (int g = 0; g < 2 * NB; g++) begin
      for (int p = 0; p < 5; p++) begin
        logic [15:0] mk, dt;
        case (p)
          0: mk = 16'h0000;
          1: mk = 16'hFFFF;
          default: mk = 16'(16'hA5C3 ^ (g * 16'h1357) ^ (p * 16'h0F0F));
        endcase
        dt = 16'(16'h3C96 + g * 16'h2221 + p * 16'h7777);
        wr(AW'(4 * g), {mk, dt});
        m_out[g*16 +: 16] = (dt & ~mk) | (m_out[g*16 +: 16] & mk);
        chk("R2 masked write", pad_out, m_out);
        chk("R10 pad_oe unchanged", pad_oe, '0);
        rd(AW'(4 * g), r);
        chk("R3 readback", PINS'(r), PINS'({16'h0, m_out[g*16 +: 16]}));
      end
    end

    // R4/R5/R6 direction and enable per bank
    for (int b = 0; b < NB; b++) begin
      logic [DW-1:0] dv, ov;
      dv = 32'hFF00_F0F0 ^ (b * 32'h1111_1111);
      ov = 32'hF0F0_CCCC ^ (b * 32'h0101_0303);
      wr(AW'('h204 + 'h40 * b), dv);
      m_dir[b*DW +: DW] = dv;
      chk("R6 dir only no drive", pad_oe, m_dir & m_oe);
      wr(AW'('h208 + 'h40 * b), ov);
      m_oe[b*DW +: DW] = ov;
      chk("R6 pad_oe = dir & oe", pad_oe, m_dir & m_oe);
      chk("R6 pad_out keeps latch", pad_out, m_out);
      rd(AW'('h204 + 'h40 * b), r);
      chk("R4 dir readback", PINS'(r), PINS'(dv));
      rd(AW'('h208 + 'h40 * b), r);
      chk("R5 oe readback", PINS'(r), PINS'(ov));
    end
    // R6 release bank 0 via direction clear
    wr(AW'('h204), '0);
    m_dir[31:0] = '0;
    chk("R6 release bank0", pad_oe, m_dir & m_oe);

    // R7 input synchronizer latency per bank
    for (int b = 0; b < NB; b++) begin
      logic [DW-1:0] v, old;
      old = pad_in[b*DW +: DW];
      v = 32'hDEAD_0001 ^ (b * 32'h0F1E_2D3C);
      @(negedge clk);
      pad_in[b*DW +: DW] = v;
      rd(AW'('h060 + 4 * b), r);
      chk("R7 not visible at edge 1", PINS'(r), PINS'(old));
      rd(AW'('h060 + 4 * b), r);
      rd(AW'('h060 + 4 * b), r);
      chk("R7 visible at edge 3", PINS'(r), PINS'(v));
    end

    // R8 ignored writes and unmapped reads
    wr(AW'('h060), 32'hFFFF_FFFF);
    wr(AW'('h020), 32'h0000_FFFF);
    wr(AW'('h206), 32'hFFFF_FFFF);
    wr(AW'('h304), 32'hFFFF_FFFF);
    wr(AW'('h002), 32'h0000_0000);
    chk("R8 pad_out untouched", pad_out, m_out);
    chk("R8 pad_oe untouched", pad_oe, m_dir & m_oe);
    rd(AW'('h060), r);
    chk("R8 input reg untouched", PINS'(r), PINS'(pad_in[31:0]));
    rd(AW'('h020), r);  chk("R8 unmapped 0x020", PINS'(r), '0);
    rd(AW'('h206), r);  chk("R8 misaligned", PINS'(r), '0);
    rd(AW'('h304), r);  chk("R8 bank out of range", PINS'(r), '0);
    rd(AW'('h070), r);  chk("R8 past input regs", PINS'(r), '0);
    rd(AW'('h100), r);  chk("R8 unmapped 0x100", PINS'(r), '0);

    // R9 no rvalid after write or idle
    wr(AW'('h000), 32'hFFFF_0000);
    chk("R9 no rvalid after write", PINS'(bus_rvalid), '0);
    @(negedge clk);
    chk("R9 no rvalid idle", PINS'(bus_rvalid), '0);

    // R10 hold without writes
    repeat (5) @(negedge clk);
    chk("R10 pad_out hold", pad_out, m_out);
    chk("R10 pad_oe hold", pad_oe, m_dir & m_oe);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule